// File: doc/BRIEF.md
# Half-Precision to 8-bit Normalized Converter

This block turns a 16-bit half-precision floating-point code, expected to hold a value from 0.0 to 1.0 inclusive, into an 8-bit unsigned normalized byte. 0.0 becomes 0x00 and 1.0 becomes 0xFF. Codes in between become the nearest integer to value × 255, and an exact half rounds up. The datapath uses only integers. The significand, with its hidden leading one restored, is multiplied by 255. A barrel shifter then aligns the product using the exponent, and a final add-one-and-halve step does the rounding. Zero and subnormal codes go through the same path and come out as zero.

Codes outside the legal range do not produce undefined bytes. They raise an out-of-range flag and the output saturates to a defined value. The block registers its outputs once, so a result appears one clock after its input is presented.

Top module: `half_to_unorm8`

## Requirements
- R1: While rst_ni is low, out_o is 0x00 and oor_o is 0.
- R2: Every result appears on out_o and oor_o at the first rising clock edge after in_i is applied, and holds until the next edge.
- R3: Input fields are sign at bit 15, exponent at bits 14:10 and mantissa at bits 9:0. Code 0x3C00 (1.0) gives out_o = 0xFF with oor_o = 0.
- R4: Code 0x0000 gives out_o = 0x00 with oor_o = 0.
- R5: Every code from 0x0000 through 0x3C00 gives oor_o = 0. For these codes out_o equals value × 255 rounded to the nearest integer, with exact halves rounded up.
- R6: Every code whose exponent field is 0 and whose sign is 0 (zero and subnormals) gives out_o = 0x00.
- R7: Any code with bit 15 set, 0x8000 included, gives oor_o = 1 and out_o = 0x00.
- R8: Any code with bit 15 clear that is above 0x3C00, infinity and NaN codes included, gives oor_o = 1 and out_o = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | 16 | Half-precision input code |
| out_o | output | 8 | Normalized byte result, registered |
| oor_o | output | 1 | Registered flag: input outside [0.0, 1.0] |

## Verification
The hardest cases to reach are the rounding ties and near-ties, where value × 255 sits exactly on or just beside a .5 boundary. An off-by-one in the shift amount or in the rounding bias only shows up on a few scattered codes. For that reason the stimulus sweeps every legal code from 0x0000 to 0x3C00 in order. Each result is compared with an exact rational rounding computed in wide integers. The two saturation paths are reached with a list of boundary codes: 0x3C01, 0x8000, infinity, NaN and the largest negative code.

// File: rtl/h2u_pkg.sv
package h2u_pkg;
  parameter int MAN_W = 10;
  parameter int EXP_W = 5;
  parameter int OUT_W = 8;
  parameter int BIAS  = 15;

  localparam int CODE_W     = 1 + EXP_W + MAN_W;
  localparam int SIG_W      = MAN_W + 1;
  localparam int PROD_W     = SIG_W + OUT_W;
  localparam int SHIFT_BASE = BIAS + MAN_W - 1;
  localparam int SH_W       = $clog2(SHIFT_BASE + 1);
  localparam logic [CODE_W-1:0] ONE_CODE = CODE_W'(BIAS) << MAN_W;

  typedef enum logic [1:0] {
    CLS_OK   = 2'd0,
    CLS_NEG  = 2'd1,
    CLS_HIGH = 2'd2
  } cls_e;
endpackage

// File: rtl/h2u_classify.sv
module h2u_classify
  import h2u_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output cls_e              cls_o
);
  always_comb begin
    if (code_i[CODE_W-1])                     cls_o = CLS_NEG;
    else if (code_i[CODE_W-2:0] > ONE_CODE[CODE_W-2:0]) cls_o = CLS_HIGH;
    else                                      cls_o = CLS_OK;
  end
endmodule

// File: rtl/h2u_scale.sv
module h2u_scale
  import h2u_pkg::*;
(
  input  logic [MAN_W-1:0]  man_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [SIG_W-1:0] sig;
  always_comb begin
    sig = {1'b1, man_i};
    // sig * (2^OUT_W - 1) as a shift and subtract
    prod_o = ({{OUT_W{1'b0}}, sig} << OUT_W) - {{OUT_W{1'b0}}, sig};
  end
endmodule

// File: rtl/h2u_shift.sv
module h2u_shift
  import h2u_pkg::*;
(
  input  logic [PROD_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [PROD_W-1:0] val_o
);
  logic [PROD_W-1:0] stg [SH_W+1];
  assign stg[0] = val_i;
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stg[k+1] = amt_i[k] ? (stg[k] >> (1 << k)) : stg[k];
  end
  assign val_o = stg[SH_W];
endmodule

// File: rtl/half_to_unorm8.sv
module half_to_unorm8
  import h2u_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       in_i,
  output logic [7:0]        out_o,
  output logic              oor_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [MAN_W-1:0]  man_f;
  logic [PROD_W-1:0] prod, aligned;
  logic [PROD_W:0]   biased;
  logic [SH_W-1:0]   amt;
  cls_e              cls;
  logic [OUT_W-1:0]  nxt_val;
  logic              nxt_oor;

  assign man_f = in_i[MAN_W-1:0];
  assign exp_f = in_i[MAN_W +: EXP_W];
  assign amt   = SH_W'(SHIFT_BASE) - SH_W'(exp_f);

  h2u_classify u_cls (.code_i(in_i), .cls_o(cls));
  h2u_scale    u_scl (.man_i(man_f), .prod_o(prod));
  h2u_shift    u_shf (.val_i(prod), .amt_i(amt), .val_o(aligned));

  assign biased = {1'b0, aligned} + (PROD_W+1)'(1);

  always_comb begin
    nxt_oor = 1'b1;
    unique case (cls)
      CLS_NEG:  nxt_val = '0;
      CLS_HIGH: nxt_val = '1;
      default: begin
        nxt_val = biased[OUT_W:1];
        nxt_oor = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= '0;
      oor_o <= 1'b0;
    end else begin
      out_o <= nxt_val;
      oor_o <= nxt_oor;
    end
  end
endmodule

// File: rtl/h2u_checker.sv
module h2u_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] in_i,
  input logic [7:0]  out_o,
  input logic        oor_o
);
  a_r7_neg_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_i[15] |=> (oor_o && out_o == 8'h00));
  a_r8_high_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_i[15] && in_i[14:0] > 15'h3C00) |=> (oor_o && out_o == 8'hFF));
  a_r3_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i == 16'h3C00) |=> (!oor_o && out_o == 8'hFF));
  a_r6_subnormal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i[15:10] == 6'd0) |=> (!oor_o && out_o == 8'h00));
  a_r5_legal_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_i[15] && in_i <= 16'h3C00) |=> !oor_o);
  always @(negedge clk_i)
    if (!rst_ni) a_r1_reset: assert (out_o == 8'h00 && !oor_o);
endmodule

bind half_to_unorm8 h2u_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_i(in_i), .out_o(out_o), .oor_o(oor_o)
);

// File: tb/sim_half_to_unorm8.sv
module sim_half_to_unorm8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = 16'h0000;
  logic [7:0]  dout;
  logic        oor;
  int errors = 0;
  int checks = 0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  half_to_unorm8 u0 (.clk_i(clk), .rst_ni(rst_n), .in_i(din), .out_o(dout), .oor_o(oor));

  // {oor, byte}
  function automatic logic [8:0] model(input logic [15:0] c);
    longint num, den, r;
    int e, m;
    if (c[15]) return {1'b1, 8'h00};
    if (c > 16'h3C00) return {1'b1, 8'hFF};
    e = int'(c[14:10]);
    m = int'(c[9:0]);
    if (e == 0) begin num = m; den = 64'd1 << 24; end
    else begin num = 1024 + m; den = 64'd1 << (25 - e); end
    // floor(num*255/den + 1/2)
    r = (2 * num * 255 + den) / (2 * den);
    return {1'b0, r[7:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] c, input logic [8:0] exp);
    checks++;
    if ({oor, dout} !== exp) begin
      errors++;
      $display("FAIL %s code=%h got oor=%b out=%h exp oor=%b out=%h",
               req, c, oor, dout, exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [15:0] c, input string req);
    din = c;
    @(posedge clk);
    @(negedge clk);
    check(req, c, model(c));
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] edge_codes [8] = '{16'h3C01, 16'h7BFF, 16'h7C00, 16'h7E00,
                                    16'h8000, 16'hBC00, 16'hFFFF, 16'h7FFF};
    din = 16'h3C00;
    repeat (3) @(negedge clk);
    check("R1", din, 9'h000);
    rst_n = 1'b1;
    // R2: output reflects input only after the edge
    din = 16'h3C00;
    #1;
    check("R2", din, 9'h000);
    @(posedge clk); @(negedge clk);
    check("R2", din, 9'h0FF);
    apply(16'h3C00, "R3");
    apply(16'h0000, "R4");
    apply(16'h03FF, "R6");
    apply(16'h0001, "R6");
    apply(16'h3800, "R5"); // 0.5 -> 127.5 rounds to 128
    for (int c = 0; c <= 16'h3C00; c++) apply(16'(c), "R5");
    for (int i = 0; i < 8; i++)
      apply(edge_codes[i], edge_codes[i][15] ? "R7" : "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule